// File: doc/BRIEF.md
# Band-Limited Envelope Splitter for Switch-Mode Drive

The block splits a complex baseband sample x = (I, Q) into two drive quantities for a switch-mode transmitter. The first is a supply-control value u, which is the smoothed envelope plus a programmable offset. The second is a compensated complex drive s = x / u. The envelope is the exact integer magnitude of x. A first-order recursive low-pass with a programmable shift smooths it to give R, and u = R + offset. Any amplitude variation that the smoothed envelope no longer carries stays in s. Multiplying s by u therefore restores x.

Only one sample is processed at a time. A valid input is taken when the block is idle. A fixed number of cycles later, one output pulse presents u, both drive components and a clip flag. Clipping means |x| > u, so the drive would have to exceed unit magnitude. In that case each component is divided by the rounded-up magnitude of x instead of by u. The drive then keeps its signs and direction and has a magnitude of at most one.

Top module: `env_split`

## Requirements
- R1: After reset, out_valid, out_u, out_si, out_sq and out_clip are all zero, and the filter state is zero.
- R2: The envelope m is floor(sqrt(I*I + Q*Q)), with I and Q as two's-complement values. With shift 0 and offset 0, out_u equals m.
- R3: On each accepted sample, the filter state A (W+G bits, G fraction bits) is updated as A = A + (((m << G) - A) >>> k). The shift is an arithmetic right shift by the shift setting k. R is A >> G after this update.
- R4: out_u = R + offset. It is W+1 bits wide and never saturates.
- R5: When the filter starts from reset with k at its all-ones value, R stays 0 and out_u equals the offset.
- R6: When the sample is not clipped, each drive component is sign(c) * floor(|c| * 2^F / d), where d = u, or d = 1 if u is 0. Each component is F+2 bits wide in two's complement, so 2^F represents unit amplitude.
- R7: out_clip is 1 exactly when I*I + Q*Q > u*u.
- R8: When the sample is clipped, d is ceil(sqrt(I*I + Q*Q)). Both components keep their signs, and out_si^2 + out_sq^2 <= 2^(2F).
- R9: out_valid is high for one cycle, W+3+2*(W+F) clock edges after the edge that accepted the sample. The outputs change only with that pulse and hold between pulses.
- R10: A valid input that arrives while a sample is in flight is ignored. It produces no output pulse and does not alter the filter.
- R11: A zero sample with u = 0 gives out_si = out_sq = 0 and out_clip = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample is present; taken only when idle |
| in_i | input | W | In-phase sample, two's complement |
| in_q | input | W | Quadrature sample, two's complement |
| cfg_shift | input | KW | Filter shift k, captured with each sample |
| cfg_offset | input | W | Unsigned envelope offset, captured with each sample |
| out_valid | output | 1 | One-cycle result pulse |
| out_u | output | W+1 | Supply-control value R + offset |
| out_si | output | F+2 | In-phase drive, 2^F is unity |
| out_sq | output | F+2 | Quadrature drive, 2^F is unity |
| out_clip | output | 1 | Sample magnitude exceeded u |

## Verification
The bench sweeps a coarse grid over the full I/Q range, including the most negative code, under five settings of shift and offset. The expected envelope, filter state, clip decision and quotients are computed arithmetically for every sample. The bench targets the boundary where |x| equals u. Comparing against the truncated root there would flag clipping on non-square magnitudes or would let the drive exceed unity. It also targets the fully blocking shift, where a wrong shift width lets the envelope leak into u. A zero sample with zero u exposes a divide-by-zero that would return all-ones quotients. A second valid issued mid-computation checks that the block neither corrupts the sample in flight nor emits a spurious pulse. A wrong cycle count in either serial unit shows up as a latency mismatch.

// File: rtl/envsplit_pkg.sv
`timescale 1ns/1ps
package envsplit_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_ROOT, PH_DIVI, PH_DIVQ} phase_e;
endpackage

// File: rtl/es_root.sv
`timescale 1ns/1ps
// Bit-serial integer square root: one result bit per cycle, MSB first.
module es_root #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2*W-1:0] rad_in,
    output logic           done,
    output logic [W-1:0]   root
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [2*W-1:0] rad;
        logic [W-1:0]   root;
        logic [BW-1:0]  idx;
        logic           busy;
        logic           done;
    } st_t;

    st_t s_d, s_q;
    logic [W-1:0]   trial;
    logic [2*W-1:0] trial_sq;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        trial    = s_q.root | (W'(1) << s_q.idx);
        trial_sq = {{W{1'b0}}, trial} * {{W{1'b0}}, trial};
        if (start) begin
            s_d.rad  = rad_in;
            s_d.root = '0;
            s_d.idx  = BW'(W - 1);
            s_d.busy = 1'b1;
        end else if (s_q.busy) begin
            if (trial_sq <= s_q.rad) s_d.root = trial;
            if (s_q.idx == '0) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.idx = s_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done = s_q.done;
    assign root = s_q.root;
endmodule

// File: rtl/es_div.sv
`timescale 1ns/1ps
// Restoring divider, one quotient bit per cycle; divisor latched at start.
module es_div #(
    parameter int NB = 14,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NB-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [NB-1:0] quo
);
    localparam int CW = $clog2(NB + 1);

    typedef struct packed {
        logic [DW-1:0] rem;
        logic [DW-1:0] den;
        logic [NB-1:0] qsh;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } st_t;

    st_t s_d, s_q;
    logic [DW:0] shifted;
    logic        qbit;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        shifted  = {s_q.rem, s_q.qsh[NB-1]};
        qbit     = (shifted >= {1'b0, s_q.den});
        if (start) begin
            s_d.rem  = '0;
            s_d.den  = den;
            s_d.qsh  = num;
            s_d.cnt  = CW'(NB);
            s_d.busy = 1'b1;
        end else if (s_q.busy) begin
            s_d.rem = qbit ? DW'(shifted - {1'b0, s_q.den}) : shifted[DW-1:0];
            s_d.qsh = {s_q.qsh[NB-2:0], qbit};
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CW'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done = s_q.done;
    assign quo  = s_q.qsh;
endmodule

// File: rtl/env_split.sv
`timescale 1ns/1ps
module env_split
    import envsplit_pkg::*;
#(
    parameter int W  = 8,
    parameter int F  = 6,
    parameter int G  = 4,
    parameter int KW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_i,
    input  logic [W-1:0]  in_q,
    input  logic [KW-1:0] cfg_shift,
    input  logic [W-1:0]  cfg_offset,
    output logic          out_valid,
    output logic [W:0]    out_u,
    output logic [F+1:0]  out_si,
    output logic [F+1:0]  out_sq,
    output logic          out_clip
);
    localparam int NB = W + F;
    localparam int DW = W + 1;
    localparam int SW = F + 2;
    localparam int AW = W + G;

    typedef struct packed {
        phase_e         ph;
        logic           neg_i;
        logic           neg_q;
        logic [W-1:0]   mag_i;
        logic [W-1:0]   mag_q;
        logic [2*W-1:0] ssq;
        logic [KW-1:0]  k;
        logic [W-1:0]   dc;
        logic [AW-1:0]  acc;
        logic [W:0]     u;
        logic           clip;
        logic [DW-1:0]  den;
        logic [NB-1:0]  res_i;
        logic           ov;
        logic [W:0]     ou;
        logic [SW-1:0]  osi;
        logic [SW-1:0]  osq;
        logic           oclip;
    } st_t;

    st_t r_d, r_q;

    logic           accept;
    logic [W-1:0]   abs_i, abs_q;
    logic [2*W-1:0] ssq_in;
    logic           root_done;
    logic [W-1:0]   root;
    logic signed [AW:0] diff, step;
    logic [AW-1:0]  acc_new;
    logic [W:0]     u_new;
    logic [2*W+1:0] u_sq;
    logic [2*W-1:0] root_sq;
    logic           clip_new;
    logic [DW-1:0]  ceil_root, den_new;
    logic           div_start, div_done;
    logic [NB-1:0]  div_num, div_quo;
    logic [DW-1:0]  div_den;

    function automatic logic [SW-1:0] apply_sign(input logic [NB-1:0] q, input logic n);
        logic [SW-1:0] t;
        t = SW'(q);
        return n ? (~t + 1'b1) : t;
    endfunction

    assign accept = in_valid && (r_q.ph == PH_IDLE);
    assign abs_i  = in_i[W-1] ? (~in_i + 1'b1) : in_i;
    assign abs_q  = in_q[W-1] ? (~in_q + 1'b1) : in_q;
    assign ssq_in = {{W{1'b0}}, abs_i} * {{W{1'b0}}, abs_i}
                  + {{W{1'b0}}, abs_q} * {{W{1'b0}}, abs_q};

    es_root #(.W(W)) u_root (
        .clk(clk), .rst_n(rst_n), .start(accept), .rad_in(ssq_in),
        .done(root_done), .root(root)
    );

    // envelope smoothing, supply value and clip decision
    assign diff      = $signed({1'b0, root, {G{1'b0}}}) - $signed({1'b0, r_q.acc});
    assign step      = diff >>> r_q.k;
    assign acc_new   = r_q.acc + AW'(step);
    assign u_new     = {1'b0, acc_new[AW-1:G]} + {1'b0, r_q.dc};
    assign u_sq      = {{(W+1){1'b0}}, u_new} * {{(W+1){1'b0}}, u_new};
    assign root_sq   = {{W{1'b0}}, root} * {{W{1'b0}}, root};
    assign clip_new  = {2'b00, r_q.ssq} > u_sq;
    assign ceil_root = {1'b0, root} + DW'(root_sq != r_q.ssq);
    assign den_new   = clip_new ? ceil_root : ((u_new == '0) ? DW'(1) : u_new);

    assign div_start = ((r_q.ph == PH_ROOT) && root_done) || ((r_q.ph == PH_DIVI) && div_done);
    assign div_num   = (r_q.ph == PH_ROOT) ? {r_q.mag_i, {F{1'b0}}} : {r_q.mag_q, {F{1'b0}}};
    assign div_den   = (r_q.ph == PH_ROOT) ? den_new : r_q.den;

    es_div #(.NB(NB), .DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(div_den),
        .done(div_done), .quo(div_quo)
    );

    always_comb begin
        r_d    = r_q;
        r_d.ov = 1'b0;
        unique case (r_q.ph)
            PH_IDLE: if (accept) begin
                r_d.neg_i = in_i[W-1];
                r_d.neg_q = in_q[W-1];
                r_d.mag_i = abs_i;
                r_d.mag_q = abs_q;
                r_d.ssq   = ssq_in;
                r_d.k     = cfg_shift;
                r_d.dc    = cfg_offset;
                r_d.ph    = PH_ROOT;
            end
            PH_ROOT: if (root_done) begin
                r_d.acc  = acc_new;
                r_d.u    = u_new;
                r_d.clip = clip_new;
                r_d.den  = den_new;
                r_d.ph   = PH_DIVI;
            end
            PH_DIVI: if (div_done) begin
                r_d.res_i = div_quo;
                r_d.ph    = PH_DIVQ;
            end
            PH_DIVQ: if (div_done) begin
                r_d.ov    = 1'b1;
                r_d.ou    = r_q.u;
                r_d.osi   = apply_sign(r_q.res_i, r_q.neg_i);
                r_d.osq   = apply_sign(div_quo, r_q.neg_q);
                r_d.oclip = r_q.clip;
                r_d.ph    = PH_IDLE;
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_valid = r_q.ov;
    assign out_u     = r_q.ou;
    assign out_si    = r_q.osi;
    assign out_sq    = r_q.osq;
    assign out_clip  = r_q.oclip;
endmodule

// File: rtl/env_split_chk.sv
`timescale 1ns/1ps
module env_split_chk #(
    parameter int W = 8,
    parameter int F = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         out_valid,
    input logic [W:0]   out_u,
    input logic [F+1:0] out_si,
    input logic [F+1:0] out_sq,
    input logic         out_clip
);
    localparam int SW = F + 2;
    localparam logic signed [SW-1:0] PMAX = SW'(1 << F);
    localparam logic [2*SW:0] LIM2 = (2*SW+1)'(1) << (2*F);

    logic signed [SW-1:0] a, b;
    logic signed [2*SW:0] mag2;
    assign a    = out_si;
    assign b    = out_sq;
    assign mag2 = a * a + b * b;

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(out_u) || !$stable(out_si) || !$stable(out_sq) || !$stable(out_clip)) |-> out_valid);

    p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (a <= PMAX && a >= -PMAX && b <= PMAX && b >= -PMAX));

    p_unit_mag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_clip) |-> (mag2 <= $signed(LIM2)));

    p_zero_u_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_u == '0 && !out_clip) |-> (out_si == '0 && out_sq == '0));
endmodule

bind env_split env_split_chk #(.W(W), .F(F)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_u(out_u),
    .out_si(out_si), .out_sq(out_sq), .out_clip(out_clip)
);

// File: tb/sim_env_split.sv
`timescale 1ns/1ps
module sim_env_split;
    localparam int W   = 8;
    localparam int F   = 6;
    localparam int G   = 4;
    localparam int KW  = 4;
    localparam int LAT = W + 3 + 2 * (W + F);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_i = '0, in_q = '0;
    logic [KW-1:0] cfg_shift = '0;
    logic [W-1:0]  cfg_offset = '0;
    logic          out_valid;
    logic [W:0]    out_u;
    logic [F+1:0]  out_si, out_sq;
    logic          out_clip;

    int n_chk = 0, n_bad = 0;
    int acc_m = 0, cur_k = 0, cur_dc = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    env_split #(.W(W), .F(F), .G(G), .KW(KW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cfg_shift(cfg_shift), .cfg_offset(cfg_offset), .out_valid(out_valid),
        .out_u(out_u), .out_si(out_si), .out_sq(out_sq), .out_clip(out_clip)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int isqrt(input int v);
        int r = 0;
        while ((r + 1) * (r + 1) <= v) r++;
        return r;
    endfunction

    task automatic do_reset(input int k, input int dc);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        cfg_shift = k[KW-1:0]; cfg_offset = dc[W-1:0];
        cur_k = k; cur_dc = dc; acc_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input int i, input int q, input string ulab, input bit intrude);
        int ai, aq, ssq, m, u, den, ei, eq, cnt, seen;
        bit clip;
        ai = (i < 0) ? -i : i;
        aq = (q < 0) ? -q : q;
        ssq = ai * ai + aq * aq;
        m = isqrt(ssq);
        acc_m = acc_m + (((m << G) - acc_m) >>> cur_k);
        u = (acc_m >>> G) + cur_dc;
        clip = ssq > u * u;
        den = clip ? (m + ((m * m != ssq) ? 1 : 0)) : ((u == 0) ? 1 : u);
        ei = (ai << F) / den; if (i < 0) ei = -ei;
        eq = (aq << F) / den; if (q < 0) eq = -eq;

        @(negedge clk);
        in_valid = 1'b1; in_i = i[W-1:0]; in_q = q[W-1:0];
        @(negedge clk);
        in_valid = 1'b0;
        cnt = 0;
        while (!out_valid && cnt < 300) begin
            @(negedge clk);
            cnt++;
            if (intrude && cnt == 5) begin
                in_valid = 1'b1; in_i = 8'sd100; in_q = -8'sd100;
            end else if (intrude && cnt == 6) begin
                in_valid = 1'b0;
            end
        end
        chk("R9", "latency", cnt, LAT);
        chk(ulab, "u", int'(out_u), u);
        chk(clip ? "R8" : "R6", "s_i", int'($signed(out_si)), ei);
        chk(clip ? "R8" : "R6", "s_q", int'($signed(out_sq)), eq);
        chk("R7", "clip", int'(out_clip), int'(clip));
        @(negedge clk);
        chk("R9", "pulse width", int'(out_valid), 0);
        chk("R9", "hold u", int'(out_u), u);
        if (intrude) begin
            seen = 0;
            for (int c = 0; c < LAT + 5; c++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            chk("R10", "extra pulse", seen, 0);
            chk("R10", "u after ignore", int'(out_u), u);
        end
    endtask

    task automatic grid(input string ulab);
        for (int a = -128; a <= 127; a += 17)
            for (int b = -128; b <= 127; b += 17)
                run(a, b, ulab, 1'b0);
    endtask

    task automatic finish_up;
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        do_reset(0, 0);
        @(negedge clk);
        chk("R1", "valid", int'(out_valid), 0);
        chk("R1", "u", int'(out_u), 0);
        chk("R1", "s_i", int'(out_si), 0);
        chk("R1", "s_q", int'(out_sq), 0);
        chk("R1", "clip", int'(out_clip), 0);
        // R11: zero sample with zero supply value
        run(0, 0, "R11", 1'b0);
        grid("R2");
        run(3, 4, "R2", 1'b0);
        run(-128, -128, "R2", 1'b0);

        do_reset(2, 20);
        grid("R3");
        // R10: second valid during computation is dropped
        run(50, -30, "R3", 1'b1);
        run(-7, 90, "R3", 1'b0);

        do_reset(1, 90);
        grid("R4");

        do_reset(3, 200);
        grid("R4");

        // R5: all-ones shift keeps the envelope out of u
        do_reset((1 << KW) - 1, 64);
        grid("R5");
        run(40, 0, "R5", 1'b0);
        run(0, -64, "R5", 1'b0);

        finish_up();
    end
endmodule